// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block draws solid rectangles and copies rectangles within a frame buffer of 16-bit pixels held in local memory. Software feeds it 32-bit command words. The top byte of each word selects the action and the lower bits carry the operand. Parameter words set up the destination and source addresses, the rectangle size, the line pitch in pixels and the fill colour. A start word then launches the operation.

The engine walks the rectangle row by row. It accesses one pixel per cycle on a simple synchronous memory port, and read data returns one cycle after a read is requested. A fill writes one pixel every cycle. A copy reads a source pixel and writes it to the destination on the next cycle.

Completion sets a sticky status bit that is cleared by writing a one to it. A busy bit is high while the engine has work. A start that arrives during an operation is held in a single slot and runs after the current operation ends.

Top module: `rect_blitter`

## Requirements
- R1: The opcode is `cmd_data[31:24]` of an accepted word, where a word is accepted when `cmd_valid` and `cmd_ready` are both high. Words with any opcode other than 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x21, 0x23 and 0x40 change nothing and start nothing.
- R2: Opcode 0x0C loads the destination byte address and opcode 0x0D loads the source byte address. Each takes operand bits 23:1, and bit 0 is forced to zero, so every memory access uses an even address.
- R3: Opcode 0x0E loads the width minus one and opcode 0x0F loads the height minus one, each from operand bits 9:0 with the higher bits discarded. Opcode 0x40 loads the line pitch in pixels from bits 10:0.
- R4: Opcode 0x0B loads the 16-bit colour from bits 15:0. Opcode 0x23 starts a fill that writes this colour to each of the (W+1)×(H+1) pixels, one write per cycle, in row-major order.
- R5: Pixel (x, y) of a rectangle lies at byte address start + (y × pitch + x) × 2.
- R6: Opcode 0x21 starts a copy. For each pixel, in row-major order, the engine reads the source address in one cycle and writes the returned data to the destination address in the next cycle. Read and write never occur in the same cycle. Overlapping regions get no special treatment.
- R7: `int_status[0]` is set in the cycle the last pixel is written. Writing with `int_clr_we` high and `int_clr_data[0]` high clears it. If a clear and a completion fall in the same cycle, the bit is set. All other `int_status` bits read zero.
- R8: `exec_status[1]` reads 1 from the cycle after a start is accepted until the operation and any held start have finished. A fill keeps it high for N cycles and a copy for 2N cycles, where N is the pixel count. All other `exec_status` bits read zero.
- R9: A start accepted while busy is held. `cmd_ready` stays low while a start is held. The held operation is launched in the cycle after the current one ends, using the parameters as they stand at that point.
- R10: After reset, the engine is idle, both status words are zero, `cmd_ready` is high and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word present |
| cmd_data | input | 32 | Command word: opcode in 31:24, operand below |
| cmd_ready | output | 1 | Low while a start is held |
| mem_addr | output | 24 | Byte address of the pixel access |
| mem_re | output | 1 | Pixel read request |
| mem_we | output | 1 | Pixel write strobe |
| mem_wdata | output | 16 | Pixel write data |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_re` |
| int_clr_we | input | 1 | Write strobe for the interrupt status clear |
| int_clr_data | input | 16 | Write-one-to-clear mask |
| int_status | output | 16 | Bit 0: operation complete |
| exec_status | output | 16 | Bit 1: operation in progress |

## Verification
The case hardest to reach from the ports is a start held behind a running operation. This needs a second start word in the cycle right after the first, before the fill ends. The held copy must then run with the parameters left in place, and the busy bit must stay high through the gap between the two operations.

The stimulus sends the two starts back to back. It checks that `cmd_ready` is low, counts the cycles the busy bit stays high and the writes made, and compares the whole memory against a model. An overlapping copy is also run, so the read-then-write order per pixel can be seen in the final memory contents.

// File: rtl/rect_blitter.sv
module rect_blitter #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 10,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [31:0]   cmd_data,
  output logic          cmd_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          int_clr_we,
  input  logic [15:0]   int_clr_data,
  output logic [15:0]   int_status,
  output logic [15:0]   exec_status
);
  localparam logic [7:0] OP_COL = 8'h0B, OP_DST = 8'h0C, OP_SRC = 8'h0D,
                         OP_WID = 8'h0E, OP_HGT = 8'h0F, OP_CPY = 8'h21,
                         OP_FIL = 8'h23, OP_PIT = 8'h40;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_RD, S_WR} st_t;
  st_t st;

  logic [AW-1:0] p_dst, p_src, drow, dcur, srow, scur;
  logic [CW-1:0] p_wm1, p_hm1, wm1, hm1, xc, yc;
  logic [LW-1:0] p_pit, pit;
  logic [DW-1:0] p_col, col;
  logic          pend, pend_cpy, done;

  wire [7:0] op     = cmd_data[31:24];
  wire       acc    = cmd_valid & cmd_ready;
  wire       go_fil = acc & (op == OP_FIL);
  wire       go_cpy = acc & (op == OP_CPY);
  wire       idle   = (st == S_IDLE);
  wire       launch = idle & (pend | go_fil | go_cpy);
  wire       l_cpy  = pend ? pend_cpy : go_cpy;
  wire       step   = (st == S_FILL) | (st == S_WR);
  wire       last_x = (xc == wm1);
  wire       last   = last_x & (yc == hm1);
  wire [AW-1:0] rstep = AW'({pit, 1'b0});

  assign cmd_ready   = ~pend;
  assign mem_re      = (st == S_RD);
  assign mem_we      = step;
  assign mem_addr    = mem_re ? scur : dcur;
  assign mem_wdata   = (st == S_FILL) ? col : mem_rdata;
  assign int_status  = {15'd0, done};
  assign exec_status = {14'd0, ~idle | pend, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {p_dst, p_src, drow, dcur, srow, scur} <= '0;
      {p_wm1, p_hm1, wm1, hm1, xc, yc} <= '0;
      {p_pit, pit, p_col, col} <= '0;
      {pend, pend_cpy, done} <= '0;
    end else begin
      if (acc) begin
        case (op)
          OP_DST:  p_dst <= {cmd_data[AW-1:1], 1'b0};
          OP_SRC:  p_src <= {cmd_data[AW-1:1], 1'b0};
          OP_WID:  p_wm1 <= cmd_data[CW-1:0];
          OP_HGT:  p_hgt_load();
          OP_COL:  p_col <= cmd_data[DW-1:0];
          OP_PIT:  p_pit <= cmd_data[LW-1:0];
          default: ;
        endcase
      end
      if (!idle && (go_fil || go_cpy)) begin
        pend     <= 1'b1;
        pend_cpy <= go_cpy;
      end
      if (launch) begin
        pend <= 1'b0;
        drow <= p_dst; dcur <= p_dst;
        srow <= p_src; scur <= p_src;
        wm1 <= p_wm1; hm1 <= p_hm1; pit <= p_pit; col <= p_col;
        xc <= '0; yc <= '0;
        st <= l_cpy ? S_RD : S_FILL;
      end
      if (st == S_RD) st <= S_WR;
      if (step) begin
        if (last) st <= S_IDLE;
        else begin
          st <= (st == S_FILL) ? S_FILL : S_RD;
          if (last_x) begin
            xc <= '0; yc <= yc + 1'b1;
            drow <= drow + rstep; dcur <= drow + rstep;
            srow <= srow + rstep; scur <= srow + rstep;
          end else begin
            xc <= xc + 1'b1;
            dcur <= dcur + AW'(2); scur <= scur + AW'(2);
          end
        end
      end
      if (step && last) done <= 1'b1;
      else if (int_clr_we && int_clr_data[0]) done <= 1'b0;
    end
  end

  task automatic p_hgt_load();
    p_hm1 <= cmd_data[CW-1:0];
  endtask
endmodule

module blit_chk #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_re,
  input logic          mem_we,
  input logic          int_clr_we,
  input logic [15:0]   int_clr_data,
  input logic [15:0]   int_status,
  input logic [15:0]   exec_status
);
  AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n) (mem_re | mem_we) |-> !mem_addr[0]); // R2
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n) mem_re |=> mem_we); // R6
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !(mem_re && mem_we)); // R6
  AST_ACCESS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (mem_re | mem_we) |-> exec_status[1]); // R8
  AST_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !cmd_ready |-> exec_status[1]); // R9
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(exec_status[1]) |-> int_status[0]); // R7
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (int_clr_we && int_clr_data[0] && !mem_we) |=> !int_status[0]); // R7
endmodule

bind rect_blitter blit_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/rect_blitter_tb.sv
module rect_blitter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 1024;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, int_clr_we = 0;
  logic [31:0] cmd_data = '0;
  logic [15:0] int_clr_data = '0;
  logic cmd_ready, mem_re, mem_we;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, int_status, exec_status;

  rect_blitter u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] mem [MW];
  logic [15:0] exp_m [MW];
  logic init_req = 0;
  int wcount = 0;
  logic [23:0] last_wa = '0;
  int checks = 0, errors = 0;

  function automatic logic [15:0] pat(int i);
    return 16'(i * 37 + 5);
  endfunction

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < MW; i++) mem[i] <= pat(i);
    end else if (mem_we) begin
      mem[mem_addr[10:1]] <= mem_wdata;
      wcount  <= wcount + 1;
      last_wa <= mem_addr;
    end
    if (mem_re) mem_rdata <= mem[mem_addr[10:1]];
  end

  // kind, dst, src, w-1, h-1, pitch, colour
  localparam logic [111:0] VEC [6] = '{
    {16'd1, 16'h0000, 16'h0000, 16'd3, 16'd2, 16'd16, 16'hF800},
    {16'd1, 16'h0102, 16'h0000, 16'd0, 16'd0, 16'd16, 16'h07E0},
    {16'd0, 16'h0200, 16'h0000, 16'd3, 16'd2, 16'd16, 16'h0000},
    {16'd1, 16'h0040, 16'h0000, 16'd9, 16'd0, 16'd20, 16'h001F},
    {16'd0, 16'h0300, 16'h0010, 16'd0, 16'd4, 16'd32, 16'h0000},
    {16'd0, 16'h0022, 16'h0020, 16'd4, 16'd1, 16'd16, 16'h0000}
  };

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(logic [31:0] w);
    cmd_valid = 1; cmd_data = w;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic clr(logic [15:0] m);
    int_clr_we = 1; int_clr_data = m;
    @(negedge clk);
    int_clr_we = 0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (exec_status[1] && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic model(bit fill, int dst, int src, int wm1, int hm1, int pit, logic [15:0] c);
    for (int y = 0; y <= hm1; y++)
      for (int x = 0; x <= wm1; x++) begin
        int d = dst / 2 + y * pit + x;
        int s = src / 2 + y * pit + x;
        exp_m[d] = fill ? c : exp_m[s];
      end
  endtask

  task automatic cmp_mem(string req);
    int bad = 0, first = -1;
    for (int i = 0; i < MW; i++)
      if (mem[i] !== exp_m[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(1, req, 0, 0);
    else chk(0, req, longint'(mem[first]), longint'(exp_m[first]));
  endtask

  initial begin
    int cyc, w0;
    for (int i = 0; i < MW; i++) exp_m[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(int_status == 0 && exec_status == 0, "R10", {int_status, exec_status}, 0);
    chk(cmd_ready && !mem_we && !mem_re, "R10", {cmd_ready, mem_we, mem_re}, 3'b100);
    init_req = 1; @(negedge clk); init_req = 0;

    for (int v = 0; v < 6; v++) begin
      logic [111:0] e = VEC[v];
      bit fill = e[96];
      int dst = int'(e[95:80]), src = int'(e[79:64]), wm1 = int'(e[63:48]);
      int hm1 = int'(e[47:32]), pit = int'(e[31:16]);
      int n = (wm1 + 1) * (hm1 + 1);
      send({8'h40, 24'(pit)});
      send({8'h0C, 24'(dst)});
      send({8'h0D, 24'(src)});
      send({8'h0E, 24'(wm1)});
      send({8'h0F, 24'(hm1)});
      send({8'h0B, 8'h00, e[15:0]});
      w0 = wcount;
      send(fill ? 32'h2300_0000 : 32'h2100_0000);
      wait_idle(cyc);
      model(fill, dst, src, wm1, hm1, pit, e[15:0]);
      chk(cyc == (fill ? n : 2 * n), fill ? "R4 R8 fill cycles" : "R6 R8 copy cycles", cyc, fill ? n : 2 * n);
      chk(wcount - w0 == n, "R5 write count", wcount - w0, n);
      cmp_mem(fill ? "R4 R5 fill memory" : "R6 R5 copy memory");
      chk(int_status == 16'h0001, "R7 done set", int_status, 1);
      clr(16'h0001);
    end

    // R2 odd address forced even
    send(32'h0C00_0111); send(32'h0E00_0000); send(32'h0F00_0000);
    send(32'h0B00_ABCD); send(32'h2300_0000);
    wait_idle(cyc);
    exp_m[16'h88] = 16'hABCD;
    chk(last_wa == 24'h110, "R2 even address", last_wa, 24'h110);
    cmp_mem("R2 memory");

    // R3 width operand masked to 10 bits
    w0 = wcount;
    send(32'h0EFF_FC01); send(32'h2300_0000);
    wait_idle(cyc);
    exp_m[16'h89] = 16'hABCD;
    chk(wcount - w0 == 2, "R3 width mask", wcount - w0, 2);
    chk(last_wa == 24'h112, "R3 last address", last_wa, 24'h112);

    // R7 clear semantics
    clr(16'hFFFE);
    chk(int_status[0] == 1'b1, "R7 clear ignored without bit0", int_status, 1);
    clr(16'h0001);
    chk(int_status == 0, "R7 write one clears", int_status, 0);

    // R1 unknown opcodes
    send(32'h05FF_FFFF); send(32'h2200_0000);
    chk(exec_status == 0 && wcount - w0 == 2, "R1 no start", exec_status, 0);
    w0 = wcount;
    send(32'h2300_0000);
    wait_idle(cyc);
    chk(wcount - w0 == 2 && last_wa == 24'h112, "R1 params kept", last_wa, 24'h112);
    cmp_mem("R1 memory");
    clr(16'h0001);

    // R9 held start
    send(32'h4000_0010); send(32'h0C00_0600); send(32'h0D00_0000);
    send(32'h0E00_0003); send(32'h0F00_0000); send(32'h0B00_1234);
    w0 = wcount;
    send(32'h2300_0000);
    send(32'h2100_0000);
    chk(!cmd_ready && exec_status[1], "R9 held start blocks", {cmd_ready, exec_status[1]}, 2'b01);
    wait_idle(cyc);
    model(1, 16'h600, 0, 3, 0, 16, 16'h1234);
    model(0, 16'h600, 0, 3, 0, 16, 16'h0);
    chk(cyc == 12, "R9 R8 busy across held start", cyc, 12);
    chk(wcount - w0 == 8, "R9 write count", wcount - w0, 8);
    cmp_mem("R9 memory");
    chk(cmd_ready && int_status[0], "R9 R7 end state", {cmd_ready, int_status[0]}, 2'b11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule